// File: doc/BRIEF.md
# Copy Engine Interrupt Controller

This block collects interrupt sources from a set of copy engines and turns them into one shared interrupt line. Every engine owns a host status register (copy-complete, high-watermark and low-watermark bits), a host enable register, a miscellaneous status register holding an error bit, a miscellaneous enable register, and a watermark register that packs a low mark and a high mark. The copy engines themselves are outside the block. They show up only as a copy-complete pulse, an error pulse and a ring occupancy value per engine.

Watermark events come from the block itself. It compares each engine's occupancy with that engine's two marks and raises an event on the cycle where occupancy first crosses a mark. A global summary register shows which engines have an enabled pending source. Its bits are ORed and registered onto `irq_o`. Software reads and writes every register through a flat register port with combinational read data. It clears status bits by writing a mask, where a one clears the bit.

Top module: `ce_irq_ctrl`

## Requirements
- R1: After reset every status and enable bit is 0, each engine's low mark is 0, its high mark equals the RING_SIZE parameter (default 16), and `irq_o` is 0.
- R2: A copy-complete pulse on `cc_evt_i[e]` sets host status bit 0 of engine e at the next clock edge, whatever the enables hold.
- R3: A write to a host status register clears each bit whose data bit is 1 and leaves each bit whose data bit is 0. Copy-complete (bit 0), high-watermark (bit 1) and low-watermark (bit 2) therefore clear independently.
- R4: When an event and a clear hit the same status bit in the same cycle, the event wins and the bit stays 1.
- R5: The high-watermark bit sets on the edge that samples occupancy strictly above the high mark while the previous sample was not above it. Occupancy that stays above the mark raises no new event after a clear.
- R6: The low-watermark bit sets on the edge that samples occupancy strictly below the low mark while the previous sample was not below it.
- R7: An error pulse on `err_evt_i[e]` sets bit 0 of engine e's miscellaneous status register. Writing a 1 to that bit clears it.
- R8: Summary bit e (read at the global address, bit e) equals (cc status AND enable bit 0) OR ((high OR low watermark status) AND enable bit 1) OR (error status AND miscellaneous enable bit 0).
- R9: `irq_o` equals the OR of all summary bits, delayed by one clock.
- R10: The host enable register (bits 1:0) and the miscellaneous enable register (bit 0) read back as written. The watermark register reads back low mark in bits OCC_W-1:0 and high mark in bits 2*OCC_W-1:OCC_W. Unused bits read 0, and a write to one engine leaves every other engine unchanged.
- R11: Address layout is {global, engine, select}. Select codes are 0 host status, 1 host enable, 2 misc status, 3 misc enable, 4 watermark. Codes 5 to 7 read 0 and ignore writes. When the global bit is set, the summary is read and writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1+clog2(NUM_ENG)+3 | Register address {global, engine, select} |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Combinational read data for `addr_i` |
| cc_evt_i | input | NUM_ENG | Copy-complete pulses, one per engine |
| err_evt_i | input | NUM_ENG | Error pulses, one per engine |
| occ_i | input | NUM_ENG*OCC_W | Ring occupancy per engine, engine e at bits e*OCC_W upward |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench targets the cycle where a clear and a new event collide on one bit. A design that let the clear win would drop a completion and never report it. It also holds occupancy above the high mark across a clear: a level-based detector would keep re-raising the bit there, and a missing edge detector would show up as an interrupt storm. It separates the watermark enable from the copy-complete enable, where a swapped mask would raise the summary for the wrong source. It also checks the one-cycle lag of `irq_o` behind the summary, where a combinational or twice-registered output would be off by one cycle. Writes to the summary and to reserved select codes are checked to change nothing.

// File: rtl/ceic_pkg.sv
package ceic_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_HSTAT = 3'd0,
        SEL_HEN   = 3'd1,
        SEL_MSTAT = 3'd2,
        SEL_MEN   = 3'd3,
        SEL_WMARK = 3'd4
    } reg_sel_e;

    // host status: bit0 copy-complete, bit1 high mark, bit2 low mark
    typedef struct packed {
        logic wlo;
        logic whi;
        logic cc;
    } hstat_t;

    // host enable: bit0 copy-complete, bit1 watermark group
    typedef struct packed {
        logic wm_en;
        logic cc_en;
    } hen_t;

    function automatic int eng_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int addr_width(input int n);
        return 1 + eng_width(n) + SEL_W;
    endfunction

    function automatic logic pending_of(input hstat_t hs, input hen_t en,
                                        input logic ms, input logic men);
        return (hs.cc & en.cc_en) | ((hs.whi | hs.wlo) & en.wm_en) | (ms & men);
    endfunction

endpackage

// File: rtl/ceic_wm_detect.sv
module ceic_wm_detect #(
    parameter int OCC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lo_mark,
    input  logic [OCC_W-1:0] hi_mark,
    output logic             hi_evt,
    output logic             lo_evt
);

    logic above_now, below_now;
    logic above_q, below_q;

    assign above_now = occ > hi_mark;
    assign below_now = occ < lo_mark;
    assign hi_evt    = above_now & ~above_q;
    assign lo_evt    = below_now & ~below_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            above_q <= 1'b0;
            below_q <= 1'b0;
        end else begin
            above_q <= above_now;
            below_q <= below_now;
        end
    end

    // R5
    hi_single_chk: assert property (@(posedge clk) disable iff (rst)
        hi_evt |=> !hi_evt);

    // R6
    lo_single_chk: assert property (@(posedge clk) disable iff (rst)
        lo_evt |=> !lo_evt);

endmodule

// File: rtl/ceic_engine.sv
module ceic_engine
    import ceic_pkg::*;
#(
    parameter int OCC_W     = 8,
    parameter int RING_SIZE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [2*OCC_W-1:0] wdata,
    input  logic               cc_evt,
    input  logic               err_evt,
    input  logic [OCC_W-1:0]   occ,
    output logic [2*OCC_W-1:0] rdata,
    output logic               pending
);

    hstat_t           hs_q, hs_set, hs_clr;
    hen_t             hen_q;
    logic             ms_q, men_q;
    logic [OCC_W-1:0] lo_q, hi_q;
    logic             hi_evt, lo_evt;
    logic             wr_hs, wr_hen, wr_ms, wr_men, wr_wm;

    ceic_wm_detect #(.OCC_W(OCC_W)) u_wm (
        .clk     (clk),
        .rst     (rst),
        .occ     (occ),
        .lo_mark (lo_q),
        .hi_mark (hi_q),
        .hi_evt  (hi_evt),
        .lo_evt  (lo_evt)
    );

    assign wr_hs  = wr_en && (sel == SEL_HSTAT);
    assign wr_hen = wr_en && (sel == SEL_HEN);
    assign wr_ms  = wr_en && (sel == SEL_MSTAT);
    assign wr_men = wr_en && (sel == SEL_MEN);
    assign wr_wm  = wr_en && (sel == SEL_WMARK);

    assign hs_set = '{wlo: lo_evt, whi: hi_evt, cc: cc_evt};
    assign hs_clr = wr_hs ? hstat_t'(wdata[2:0]) : hstat_t'(3'b000);

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q  <= '0;
            hen_q <= '0;
            ms_q  <= 1'b0;
            men_q <= 1'b0;
            lo_q  <= '0;
            hi_q  <= OCC_W'(RING_SIZE);
        end else begin
            hs_q <= hstat_t'((hs_q & ~hs_clr) | hs_set);
            ms_q <= (ms_q & ~(wr_ms & wdata[0])) | err_evt;
            if (wr_hen) hen_q <= hen_t'(wdata[1:0]);
            if (wr_men) men_q <= wdata[0];
            if (wr_wm) begin
                lo_q <= wdata[OCC_W-1:0];
                hi_q <= wdata[2*OCC_W-1:OCC_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_HSTAT: rdata[2:0] = hs_q;
            SEL_HEN:   rdata[1:0] = hen_q;
            SEL_MSTAT: rdata[0]   = ms_q;
            SEL_MEN:   rdata[0]   = men_q;
            SEL_WMARK: rdata      = {hi_q, lo_q};
            default:   rdata      = '0;
        endcase
    end

    assign pending = pending_of(hs_q, hen_q, ms_q, men_q);

    // R2
    cc_set_chk: assert property (@(posedge clk) disable iff (rst)
        cc_evt |=> hs_q.cc);

    // R3
    cc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && wdata[0] && !cc_evt) |=> !hs_q.cc);

    // R3
    whi_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hs && !wdata[1] && hs_q.whi) |=> hs_q.whi);

    // R5
    whi_set_chk: assert property (@(posedge clk) disable iff (rst)
        hi_evt |=> hs_q.whi);

    // R6
    wlo_set_chk: assert property (@(posedge clk) disable iff (rst)
        lo_evt |=> hs_q.wlo);

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> ms_q);

    // R10
    wm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_wm |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/ce_irq_ctrl.sv
module ce_irq_ctrl
    import ceic_pkg::*;
#(
    parameter int NUM_ENG   = 8,
    parameter int OCC_W     = 8,
    parameter int DATA_W    = 32,
    parameter int RING_SIZE = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en_i,
    input  logic [addr_width(NUM_ENG)-1:0]   addr_i,
    input  logic [DATA_W-1:0]                wr_data_i,
    output logic [DATA_W-1:0]                rd_data_o,
    input  logic [NUM_ENG-1:0]               cc_evt_i,
    input  logic [NUM_ENG-1:0]               err_evt_i,
    input  logic [NUM_ENG*OCC_W-1:0]         occ_i,
    output logic                             irq_o
);

    localparam int ENG_W  = eng_width(NUM_ENG);
    localparam int ADDR_W = addr_width(NUM_ENG);
    localparam int RD_W   = 2 * OCC_W;

    logic             glb;
    logic [ENG_W-1:0] eng;
    reg_sel_e         sel;
    logic [RD_W-1:0]  eng_rd [NUM_ENG];
    logic [NUM_ENG-1:0] summary;

    assign glb = addr_i[ADDR_W-1];
    assign eng = addr_i[ADDR_W-2:SEL_W];
    assign sel = reg_sel_e'(addr_i[SEL_W-1:0]);

    generate
        for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
            logic wr_me;
            assign wr_me = wr_en_i && !glb && (eng == ENG_W'(e));

            ceic_engine #(
                .OCC_W     (OCC_W),
                .RING_SIZE (RING_SIZE)
            ) u_eng (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_me),
                .sel     (sel),
                .wdata   (wr_data_i[RD_W-1:0]),
                .cc_evt  (cc_evt_i[e]),
                .err_evt (err_evt_i[e]),
                .occ     (occ_i[e*OCC_W +: OCC_W]),
                .rdata   (eng_rd[e]),
                .pending (summary[e])
            );
        end

        if (DATA_W > RD_W) begin : g_spare
            logic unused_wdata;
            assign unused_wdata = ^wr_data_i[DATA_W-1:RD_W];
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        if (glb) begin
            rd_data_o[NUM_ENG-1:0] = summary;
        end else if (int'(eng) < NUM_ENG) begin
            rd_data_o[RD_W-1:0] = eng_rd[eng];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |summary;
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|summary) |=> irq_o);

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|summary) |=> !irq_o);

endmodule

// File: tb/ce_irq_ctrl_tb.sv
module ce_irq_ctrl_tb;

    localparam int NE      = 8;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        r_rst = 1'b1;
    logic        r_wr = 1'b0;
    logic [6:0]  r_addr = '0;
    logic [31:0] r_wdata = '0;
    logic [NE-1:0] r_cc = '0;
    logic [NE-1:0] r_err = '0;
    logic [7:0]  r_occ [NE];
    logic [NE*8-1:0] occ_flat;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model
    logic [2:0] m_hs [NE];
    logic [1:0] m_hen [NE];
    logic       m_ms [NE];
    logic       m_men [NE];
    logic [7:0] m_lo [NE];
    logic [7:0] m_hi [NE];
    bit         m_aq [NE];
    bit         m_bq [NE];
    logic       exp_irq = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    always_comb begin
        for (int e = 0; e < NE; e++) occ_flat[e*8 +: 8] = r_occ[e];
    end

    ce_irq_ctrl #(.NUM_ENG(NE), .OCC_W(8), .DATA_W(32), .RING_SIZE(16)) u_dut (
        .clk       (clk),
        .rst       (r_rst),
        .wr_en_i   (r_wr),
        .addr_i    (r_addr),
        .wr_data_i (r_wdata),
        .rd_data_o (rd_data),
        .cc_evt_i  (r_cc),
        .err_evt_i (r_err),
        .occ_i     (occ_flat),
        .irq_o     (irq)
    );

    function automatic logic sum_bit(input int e);
        return (m_hs[e][0] & m_hen[e][0]) | ((m_hs[e][1] | m_hs[e][2]) & m_hen[e][1])
               | (m_ms[e] & m_men[e]);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [6:0] a);
        logic [31:0] v;
        int e;
        v = '0;
        e = int'(a[5:3]);
        if (a[6]) begin
            for (int k = 0; k < NE; k++) v[k] = sum_bit(k);
        end else begin
            case (a[2:0])
                3'd0: v[2:0] = m_hs[e];
                3'd1: v[1:0] = m_hen[e];
                3'd2: v[0] = m_ms[e];
                3'd3: v[0] = m_men[e];
                3'd4: v[15:0] = {m_hi[e], m_lo[e]};
                default: v = '0;
            endcase
        end
        return v;
    endfunction

    function automatic logic [6:0] mk_addr(input bit g, input int e, input int s);
        return {g, 3'(e), 3'(s)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < NE; e++) begin
            m_hs[e] = '0; m_hen[e] = '0; m_ms[e] = 0; m_men[e] = 0;
            m_lo[e] = 8'd0; m_hi[e] = 8'd16; m_aq[e] = 0; m_bq[e] = 0;
        end
        exp_irq = 1'b0;
    endtask

    task automatic model_step();
        logic [NE-1:0] sum_old;
        for (int e = 0; e < NE; e++) sum_old[e] = sum_bit(e);
        for (int e = 0; e < NE; e++) begin
            bit hn, ln, hev, lev;
            logic [2:0] clr;
            logic mclr;
            hn = r_occ[e] > m_hi[e];
            ln = r_occ[e] < m_lo[e];
            hev = hn && !m_aq[e];
            lev = ln && !m_bq[e];
            m_aq[e] = hn;
            m_bq[e] = ln;
            clr = '0;
            mclr = 1'b0;
            if (r_wr && !r_addr[6] && int'(r_addr[5:3]) == e) begin
                case (r_addr[2:0])
                    3'd0: clr = r_wdata[2:0];
                    3'd1: m_hen[e] = r_wdata[1:0];
                    3'd2: mclr = r_wdata[0];
                    3'd3: m_men[e] = r_wdata[0];
                    3'd4: begin m_lo[e] = r_wdata[7:0]; m_hi[e] = r_wdata[15:8]; end
                    default: ;
                endcase
            end
            m_hs[e] = (m_hs[e] & ~clr) | {lev, hev, r_cc[e]};
            m_ms[e] = (m_ms[e] & ~mclr) | r_err[e];
        end
        exp_irq = |sum_old;
    endtask

    // one clock: inputs already driven at a falling edge
    task automatic tick();
        string tag;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(irq == exp_irq, "R9 irq", {31'b0, irq}, {31'b0, exp_irq});
        if (r_addr[6])               tag = "R8 summary";
        else if (r_addr[2:0] == 3'd4) tag = "R10 wmark";
        else if (r_addr[2:0] > 3'd4)  tag = "R11 reserved";
        else                         tag = "R3 status/enable";
        check(rd_data == exp_rd(r_addr), tag, rd_data, exp_rd(r_addr));
        r_wr = 1'b0;
        r_cc = '0;
        r_err = '0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        r_wr = 1'b1; r_addr = a; r_wdata = d;
        tick();
    endtask

    task automatic peek(input logic [6:0] a, input logic [31:0] exp, input string req);
        r_addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < NE; e++) r_occ[e] = 8'd0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        r_rst = 1'b0;

        // R1 reset values
        peek(mk_addr(0, 0, 0), 32'h0, "R1 hstat");
        peek(mk_addr(0, 3, 4), 32'h1000, "R1 wmark");
        peek(mk_addr(0, 5, 1), 32'h0, "R1 hen");
        peek(mk_addr(1, 0, 0), 32'h0, "R1 summary");
        check(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);

        // R2 copy-complete sets status even when disabled
        r_cc[2] = 1'b1; r_addr = mk_addr(0, 2, 0); tick();
        peek(mk_addr(0, 2, 0), 32'h1, "R2 cc set");
        peek(mk_addr(1, 0, 0), 32'h0, "R8 disabled source");

        // R4 event beats clear
        r_cc[2] = 1'b1; wr(mk_addr(0, 2, 0), 32'h1);
        peek(mk_addr(0, 2, 0), 32'h1, "R4 set wins");
        // R3 clear
        wr(mk_addr(0, 2, 0), 32'h1);
        peek(mk_addr(0, 2, 0), 32'h0, "R3 cleared");

        // R5 high watermark on engine 1, mark 5
        wr(mk_addr(0, 1, 4), 32'h0500);
        r_occ[1] = 8'd5; tick();
        peek(mk_addr(0, 1, 0), 32'h0, "R5 equal is not above");
        r_occ[1] = 8'd6; tick();
        peek(mk_addr(0, 1, 0), 32'h2, "R5 above");
        r_occ[1] = 8'd7; wr(mk_addr(0, 1, 0), 32'h2);
        tick();
        peek(mk_addr(0, 1, 0), 32'h0, "R5 no refire while above");
        r_occ[1] = 8'd3; tick();
        r_occ[1] = 8'd9; tick();
        peek(mk_addr(0, 1, 0), 32'h2, "R5 refire after dip");
        // R3 independent clears
        r_cc[1] = 1'b1; tick();
        wr(mk_addr(0, 1, 0), 32'h1);
        peek(mk_addr(0, 1, 0), 32'h2, "R3 independent");

        // R6 low watermark mark 4
        wr(mk_addr(0, 1, 4), 32'h0504);
        r_occ[1] = 8'd4; tick();
        peek(mk_addr(0, 1, 0), 32'h2, "R6 equal is not below");
        r_occ[1] = 8'd3; tick();
        peek(mk_addr(0, 1, 0), 32'h6, "R6 below");

        // R7 error
        r_err[4] = 1'b1; tick();
        peek(mk_addr(0, 4, 2), 32'h1, "R7 err set");
        wr(mk_addr(0, 4, 2), 32'h1);
        peek(mk_addr(0, 4, 2), 32'h0, "R7 err clear");

        // R8 / R9 watermark enable raises summary, irq lags one clock
        wr(mk_addr(0, 1, 1), 32'h2);
        peek(mk_addr(1, 0, 0), 32'h2, "R8 wm enabled");
        check(irq == 1'b0, "R9 lag", {31'b0, irq}, 32'h0);
        tick();
        check(irq == 1'b1, "R9 high", {31'b0, irq}, 32'h1);

        // R11 summary and reserved writes ignored
        wr(mk_addr(1, 0, 0), 32'hFFFF_FFFF);
        peek(mk_addr(1, 0, 0), 32'h2, "R11 summary write ignored");
        wr(mk_addr(0, 0, 5), 32'hFFFF_FFFF);
        peek(mk_addr(0, 0, 5), 32'h0, "R11 reserved");
        peek(mk_addr(0, 0, 1), 32'h0, "R11 reserved write no effect");

        wr(mk_addr(0, 1, 0), 32'h7);
        peek(mk_addr(1, 0, 0), 32'h0, "R8 cleared");
        tick();
        check(irq == 1'b0, "R9 low", {31'b0, irq}, 32'h0);

        // R10 readback and isolation
        wr(mk_addr(0, 6, 1), 32'hFFFF_FFFF);
        peek(mk_addr(0, 6, 1), 32'h3, "R10 hen readback");
        peek(mk_addr(0, 7, 1), 32'h0, "R10 isolation");
        wr(mk_addr(0, 6, 3), 32'hFFFF_FFFE);
        peek(mk_addr(0, 6, 3), 32'h0, "R10 men readback");

        // constrained random
        for (int c = 0; c < 3000; c++) begin
            int s;
            s = int'($urandom % 6);
            r_wr = ($urandom % 3) == 0;
            r_addr = mk_addr(($urandom % 10) == 0, int'($urandom % NE), s);
            if (s == 4) r_wdata = {16'($urandom), 8'($urandom % 24), 8'($urandom % 12)};
            else        r_wdata = $urandom;
            for (int e = 0; e < NE; e++) begin
                r_cc[e]  = ($urandom % 8) == 0;
                r_err[e] = ($urandom % 20) == 0;
                if (($urandom % 4) == 0) r_occ[e] = 8'($urandom % 28);
            end
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-set act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule